// File: doc/BRIEF.md
# March Memory Test Sequencer

This block is a built-in self-test controller for a word-addressable memory. It drives the memory through a plain synchronous port, using address, write data, write enable and read enable, and it gets read data back one cycle after each read strobe. A single-cycle start pulse runs one full march. The march has three parts:

- It writes an all-zero background into every word.
- It walks up the address space. At each word it reads and expects zero, writes all ones, then reads again and expects all ones.
- It walks back down. At each word it reads and expects all ones, writes zero, then reads again and expects zero.

Each 8-bit word counts as one cell, and "one" means every data bit is set. Every read is compared against the value the march expects. A mismatch raises a sticky fail flag and keeps the address of the first failing read. The block holds busy high for the whole run and pulses done when the descending pass finishes.

Top module: `march_bist_seq`

## Requirements
- R1: After reset, busy, done, fail, mem_we and mem_re are all low and fail_addr is zero.
- R2: A one-cycle start pulse while idle starts a run. busy is high from the next cycle for exactly 7*2^AW+1 cycles.
- R3: The run first writes zero to every address in ascending order, one write per cycle, starting at address 0.
- R4: The ascending pass then visits addresses 0 up to 2^AW-1. Each address gets three cycles: a read expecting zero, a write of all ones (every bit 1), and a read expecting all ones.
- R5: The descending pass visits addresses 2^AW-1 down to 0. Each address gets three cycles: a read expecting all ones, a write of zero, and a read expecting zero. One idle-busy cycle follows with no memory access.
- R6: mem_we and mem_re are never high in the same cycle.
- R7: Read data is compared in the cycle after mem_re. A difference in any bit sets fail.
- R8: fail is sticky until the next accepted start, which clears it. fail_addr keeps the address of the first mismatching read, and later mismatches do not change it.
- R9: done is a one-cycle pulse in the first cycle busy is low after a run. fail and fail_addr are final at that point.
- R10: A start pulse while busy is high is ignored. The run's length, access order and result do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins a march while idle |
| busy | output | 1 | High while a march is in progress |
| done | output | 1 | One-cycle pulse at the end of a march |
| fail | output | 1 | Sticky flag: a read mismatched |
| fail_addr | output | AW | Address of the first mismatching read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DW | Read data, valid one cycle after mem_re |

## Verification
The assertions assume a memory with one cycle of read latency. They also assume start arrives as a pulse synchronous to clk, and that reset has been released through the internal synchronizer before the first start. The bench's memory model registers read data on the edge that samples mem_re. The bench drives start only at falling edges, as one-cycle pulses, and waits for the synchronizer to settle after reset. Faults are injected only as stuck bits on the model's read path, so the expected first failing address follows directly from the ascending order.

// File: rtl/march_pkg.sv
package march_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_UP_RD0,
    ST_UP_WR1,
    ST_UP_RD1,
    ST_DN_RD1,
    ST_DN_WR0,
    ST_DN_RD0,
    ST_FIN
  } march_state_e;
endpackage

// File: rtl/march_rst_sync.sv
module march_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ls
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_ls = sync_q;
endmodule

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_ls,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] addr,
  output logic          at_max,
  output logic          at_min
);
  localparam logic [AW-1:0] ADDR_MAX = {AW{1'b1}};
  localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = ld_lo | ld_hi | inc | dec;
    addr_d  = addr_q;
    if (ld_lo)      addr_d = '0;
    else if (ld_hi) addr_d = ADDR_MAX;
    else if (inc)   addr_d = addr_q + ADDR_ONE;
    else if (dec)   addr_d = addr_q - ADDR_ONE;
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls)      addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr   = addr_q;
  assign at_max = (addr_q == ADDR_MAX);
  assign at_min = (addr_q == '0);

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_ls)
    (inc && !ld_lo && !ld_hi) |=> (addr == $past(addr) + ADDR_ONE));
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_ls)
    (dec && !inc && !ld_lo && !ld_hi) |=> (addr == $past(addr) - ADDR_ONE));
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_ls)
    ld_lo |=> at_min);
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ls,
  input  logic          clr,
  input  logic          chk_en,
  input  logic          exp_ones,
  input  logic [AW-1:0] chk_addr,
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  logic          pend_q;
  logic          exp_q;
  logic [AW-1:0] addr_q;
  logic          fail_q;
  logic          fail_d;
  logic [AW-1:0] faddr_q;
  logic [AW-1:0] faddr_d;
  logic [DW-1:0] exp_word;
  logic          mism;
  logic          res_en;

  always_comb begin
    exp_word = exp_q ? {DW{1'b1}} : {DW{1'b0}};
    mism     = pend_q && (rdata != exp_word);
    res_en   = clr | mism;
    fail_d   = fail_q;
    faddr_d  = faddr_q;
    if (clr) begin
      fail_d  = 1'b0;
      faddr_d = '0;
    end else if (mism && !fail_q) begin
      fail_d  = 1'b1;
      faddr_d = addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= chk_en;
      if (chk_en) begin
        exp_q  <= exp_ones;
        addr_q <= chk_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end else if (res_en) begin
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
    end
  end

  assign fail      = fail_q;
  assign fail_addr = faddr_q;

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_ls)
    (fail && !clr) |=> fail);
  a_r8_first_addr_kept: assert property (@(posedge clk) disable iff (!rst_ls)
    (fail && !clr) |=> $stable(fail_addr));
  a_r7_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_ls)
    (mism && !clr) |=> fail);
endmodule

// File: rtl/march_bist_seq.sv
module march_bist_seq
  import march_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [DW-1:0] WORD_ONES = {DW{1'b1}};

  logic         rst_ls;
  march_state_e state_q;
  march_state_e state_d;
  logic         done_q;
  logic         ld_lo;
  logic         ld_hi;
  logic         inc;
  logic         dec;
  logic         at_max;
  logic         at_min;
  logic         accept;
  logic         exp_ones;

  march_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ls (rst_ls)
  );

  march_addr_gen #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst_ls (rst_ls),
    .ld_lo  (ld_lo),
    .ld_hi  (ld_hi),
    .inc    (inc),
    .dec    (dec),
    .addr   (mem_addr),
    .at_max (at_max),
    .at_min (at_min)
  );

  always_comb begin
    state_d  = state_q;
    ld_lo    = 1'b0;
    ld_hi    = 1'b0;
    inc      = 1'b0;
    dec      = 1'b0;
    accept   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          ld_lo   = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (at_max) begin
          ld_lo   = 1'b1;
          state_d = ST_UP_RD0;
        end else begin
          inc = 1'b1;
        end
      end
      ST_UP_RD0: state_d = ST_UP_WR1;
      ST_UP_WR1: state_d = ST_UP_RD1;
      ST_UP_RD1: begin
        if (at_max) begin
          state_d = ST_DN_RD1;
        end else begin
          inc     = 1'b1;
          state_d = ST_UP_RD0;
        end
      end
      ST_DN_RD1: state_d = ST_DN_WR0;
      ST_DN_WR0: state_d = ST_DN_RD0;
      ST_DN_RD0: begin
        if (at_min) begin
          state_d = ST_FIN;
        end else begin
          dec     = 1'b1;
          state_d = ST_DN_RD1;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FIN);
    end
  end

  always_comb begin
    mem_we    = (state_q == ST_FILL) || (state_q == ST_UP_WR1) || (state_q == ST_DN_WR0);
    mem_re    = (state_q == ST_UP_RD0) || (state_q == ST_UP_RD1) ||
                (state_q == ST_DN_RD1) || (state_q == ST_DN_RD0);
    mem_wdata = (state_q == ST_UP_WR1) ? WORD_ONES : '0;
    exp_ones  = (state_q == ST_UP_RD1) || (state_q == ST_DN_RD1);
  end

  march_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk       (clk),
    .rst_ls    (rst_ls),
    .clr       (accept),
    .chk_en    (mem_re),
    .exp_ones  (exp_ones),
    .chk_addr  (mem_addr),
    .rdata     (mem_rdata),
    .fail      (fail),
    .fail_addr (fail_addr)
  );

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  a_r6_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_ls)
    !(mem_we && mem_re));
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_ls)
    $fell(busy) |-> done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_ls)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_ls)
    done |-> !busy);
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_ls)
    (busy && start && state_q != ST_FIN) |=> busy);
  a_r4_write_ones_up: assert property (@(posedge clk) disable iff (!rst_ls)
    (mem_we && $past(mem_re) && !$past(exp_ones) && $past(busy) && state_q == ST_UP_WR1)
      |-> (mem_wdata == WORD_ONES));
endmodule

// File: tb/tb_march_bist_seq.sv
module tb_march_bist_seq;
  localparam int  AW      = 4;
  localparam int  DW      = 8;
  localparam int  N       = 1 << AW;
  localparam time CLK_PER = 10ns;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          busy;
  logic          done;
  logic          fail;
  logic [AW-1:0] fail_addr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          mem_re;
  logic [DW-1:0] mem_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  int bcount   = 0;
  int step     = 0;
  int trace_errs = 0;
  int overlaps = 0;

  logic [DW-1:0] mem [N];
  bit            fa_en   [2];
  int            fa_addr [2];
  logic [DW-1:0] fa_mask [2];
  logic [DW-1:0] fa_val  [2];

  march_bist_seq #(.AW(AW), .DW(DW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  // behavioural memory, one-cycle read latency, stuck bits on the read path
  always @(posedge clk) begin
    logic [DW-1:0] v;
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) begin
      v = mem[mem_addr];
      for (int f = 0; f < 2; f++)
        if (fa_en[f] && int'(mem_addr) == fa_addr[f])
          v = (v & ~fa_mask[f]) | (fa_val[f] & fa_mask[f]);
      mem_rdata <= v;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // expected access at busy-cycle k of a run (R3, R4, R5)
  function automatic void exp_op(int k, output bit we, output bit re,
                                 output int a, output bit ones);
    int j;
    int s;
    we = 0; re = 0; a = 0; ones = 0;
    if (k < N) begin
      we = 1; a = k;
    end else if (k < 4*N) begin
      j = k - N; a = j / 3; s = j % 3;
      we = (s == 1); re = !we; ones = (s == 1);
    end else if (k < 7*N) begin
      j = k - 4*N; a = N - 1 - j / 3; s = j % 3;
      we = (s == 1); re = !we;
    end
  endfunction

  always @(negedge clk) begin
    bit ewe;
    bit ere;
    int ea;
    bit eones;
    cyc++;
    if (rst_n && busy) begin
      exp_op(step, ewe, ere, ea, eones);
      if (mem_we !== ewe || mem_re !== ere) trace_errs++;
      else if ((ewe || ere) && int'(mem_addr) != ea) trace_errs++;
      else if (ewe && mem_wdata !== (eones ? {DW{1'b1}} : {DW{1'b0}})) trace_errs++;
      if (mem_we && mem_re) overlaps++;
      step++;
      bcount++;
    end else begin
      step = 0;
    end
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    check(0, "watchdog", cyc, 0);
    summary();
  end

  task automatic set_faults(bit e0, int a0, logic [DW-1:0] m0, logic [DW-1:0] v0,
                            bit e1, int a1, logic [DW-1:0] m1, logic [DW-1:0] v1);
    fa_en[0] = e0; fa_addr[0] = a0; fa_mask[0] = m0; fa_val[0] = v0;
    fa_en[1] = e1; fa_addr[1] = a1; fa_mask[1] = m1; fa_val[1] = v1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0, "R1 busy/done low", {busy, done}, 0);
    check(fail == 0, "R1 fail low", fail, 0);
    check(fail_addr == 0, "R1 fail_addr zero", fail_addr, 0);
    check(mem_we == 0 && mem_re == 0, "R1 strobes low", {mem_we, mem_re}, 0);
  endtask

  task automatic run_march(string tag, bit mid_start, bit exp_fail, int exp_addr);
    int guard;
    @(negedge clk);
    bcount = 0; trace_errs = 0; overlaps = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1, {"R2 busy after start ", tag}, busy, 1);
    check(fail == 0, {"R8 fail cleared by start ", tag}, fail, 0);
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (mid_start) start = (guard == 20) || (guard == 60);
      else start = 1'b0;
    end
    start = 1'b0;
    check(done == 1, {"R9 done pulse ", tag}, done, 1);
    check(busy == 0, {"R9 busy low with done ", tag}, busy, 0);
    check(bcount == 7*N + 1, {"R2 busy length ", tag}, bcount, 7*N + 1);
    check(trace_errs == 0, {"R3 R4 R5 access order ", tag}, trace_errs, 0);
    check(overlaps == 0, {"R6 no read/write overlap ", tag}, overlaps, 0);
    check(fail == exp_fail, {"R7 fail result ", tag}, fail, exp_fail);
    if (exp_fail)
      check(int'(fail_addr) == exp_addr, {"R8 first fail address ", tag},
            fail_addr, exp_addr);
    @(negedge clk);
    check(done == 0, {"R9 done one cycle ", tag}, done, 0);
  endtask

  task automatic t_clean();
    set_faults(0, 0, '0, '0, 0, 0, '0, '0);
    run_march("clean", 0, 0, 0);
  endtask

  task automatic t_stuck1_mid();
    set_faults(1, 5, 8'h01, 8'h01, 0, 0, '0, '0);
    run_march("stuck1 addr5 bit0", 0, 1, 5);
  endtask

  task automatic t_stuck0_top();
    set_faults(1, N-1, 8'h80, 8'h00, 0, 0, '0, '0);
    run_march("stuck0 top bit7", 0, 1, N-1);
  endtask

  task automatic t_stuck0_zero();
    set_faults(1, 0, 8'h10, 8'h00, 0, 0, '0, '0);
    run_march("stuck0 addr0 bit4", 0, 1, 0);
  endtask

  task automatic t_two_faults();
    set_faults(1, 9, 8'h04, 8'h04, 1, 3, 8'h20, 8'h00);
    run_march("two faults first kept", 0, 1, 3);
  endtask

  task automatic t_restart_clears();
    set_faults(0, 0, '0, '0, 0, 0, '0, '0);
    run_march("rerun clears fail", 0, 0, 0);
  endtask

  task automatic t_mid_start();
    set_faults(1, 7, 8'h02, 8'h02, 0, 0, '0, '0);
    run_march("R10 start while busy", 1, 1, 7);
  endtask

  initial begin
    set_faults(0, 0, '0, '0, 0, 0, '0, '0);
    t_reset();
    t_clean();
    t_stuck1_mid();
    t_stuck0_top();
    t_two_faults();
    t_restart_clears();
    t_stuck0_zero();
    t_mid_start();
    summary();
  end
endmodule